// File: doc/BRIEF.md
# Program Counter and Return-Address Stack

This block sequences instruction fetch for a small controller with a 13-bit program space. It holds the fetch address, an 8-bit high-address holding latch and a circular stack of return addresses. Each clock is one instruction cycle. An upstream decoder presents one event code per cycle: plain advance, absolute jump, subroutine call, one of three return flavours, a data write of the low address byte, or a taken skip.

Absolute jumps and calls take their low 11 address bits from the instruction literal and their top two bits from the holding latch. A data write to the low address byte takes the upper five bits from the latch. Any change of flow, and any taken skip, raises `flush` for the following cycle. During that cycle the instruction already fetched is treated as a no-op and every event input is ignored. A return-from-interrupt also raises a one-cycle `gie_set` pulse for the interrupt controller.

Top module: `pc_flow_unit`

## Requirements
- R1: After a synchronous reset, `fetch_addr` is 0x0000, `latch_q` is 0x00, and `flush` and `gie_set` are low.
- R2: Event code 0 (advance) sets `fetch_addr` to its previous value plus one, wrapping from 0x1FFF to 0x0000, and leaves `flush` low.
- R3: Event code 1 (jump) sets `fetch_addr` to {latch_q[4:3], lit[10:0]} and raises `flush` for the next cycle.
- R4: Event code 2 (call) stores the current `fetch_addr` (the address after the call) on the stack and then jumps exactly as in R3.
- R5: Event codes 3, 4 and 5 (return, return-with-literal, return-from-interrupt) load `fetch_addr` from the most recent stack entry, remove that entry and raise `flush`. Code 5 alone also raises `gie_set` for exactly one cycle.
- R6: Event code 6 (low-byte write) sets `fetch_addr` to {latch_q[4:0], pcl_data} and raises `flush`.
- R7: `pcl_rd` always equals `fetch_addr[7:0]`. Jumps, calls, returns and low-byte writes leave `latch_q` unchanged.
- R8: Event code 7 (taken skip) advances `fetch_addr` by one and raises `flush`.
- R9: In a cycle with `flush` high, `ev_code`, `lit`, `pcl_data`, `latch_we` and `latch_data` are ignored. `fetch_addr` advances by one and `flush` drops.
- R10: The stack holds 8 entries and is circular. A ninth push overwrites the oldest entry without any flag, so after nine calls the first eight returns yield the nine call addresses newest first (minus the oldest), and the ninth return yields the newest again.
- R11: With `latch_we` high in a non-flush cycle, `latch_q` takes `latch_data` at the next cycle. A jump issued in that same cycle uses the previous latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| ev_code | input | 3 | Flow event for the executing instruction |
| lit | input | 11 | Jump or call literal |
| pcl_data | input | 8 | Value written to the low address byte |
| latch_we | input | 1 | Write strobe for the holding latch |
| latch_data | input | 8 | Value for the holding latch |
| fetch_addr | output | 13 | Current fetch address |
| pcl_rd | output | 8 | Low address byte as read by data moves |
| latch_q | output | 8 | Holding latch contents |
| flush | output | 1 | Current fetched instruction is discarded |
| gie_set | output | 1 | Pulse that sets the global interrupt enable |

## Verification
The bench uses the default parameters: 13-bit address, 11-bit literal, 8-bit data and an 8-deep stack. With these sizes every jump literal can be swept, paired with all four values of the latch bits that feed the top of the address. Every combination of five latch bits and eight data bits can be swept for low-byte writes. The depth of eight makes the overwrite of the oldest entry reachable with nine nested calls. The same sizes expose the address wrap at 0x1FFF and the ignored inputs during flush cycles.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int EV_W = 3;

  typedef enum logic [EV_W-1:0] {
    EV_STEP   = 3'd0,
    EV_GOTO   = 3'd1,
    EV_CALL   = 3'd2,
    EV_RET    = 3'd3,
    EV_RETLIT = 3'd4,
    EV_RETINT = 3'd5,
    EV_PCLWR  = 3'd6,
    EV_SKIP   = 3'd7
  } pcu_ev_e;
endpackage

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_data,
  output logic [ADDR_W-1:0] tos
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  // Storage has no reset so that it maps onto distributed RAM.
  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  ptr_inc;
  logic [PTR_W-1:0]  ptr_dec;

  always_comb begin
    ptr_inc = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    ptr_dec = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       wr_ptr <= '0;
    else if (push) wr_ptr <= ptr_inc;
    else if (pop)  wr_ptr <= ptr_dec;
  end

  assign tos = mem[ptr_dec];
endmodule

// File: rtl/pcu_hold_latch.sv
module pcu_hold_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)               q <= '0;
    else if (accept && we) q <= wdata;
  end
endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LIT_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic                     flush_q,
  input  pcu_ev_e                  ev,
  input  logic [ADDR_W-1:0]        pc_q,
  input  logic [LIT_W-1:0]         lit,
  input  logic [DATA_W-1:0]        pcl_data,
  input  logic [ADDR_W-DATA_W-1:0] latch_hi,
  input  logic [ADDR_W-1:0]        tos,
  output logic [ADDR_W-1:0]        pc_nxt,
  output logic                     push,
  output logic                     pop,
  output logic                     flush_nxt,
  output logic                     gie_nxt
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int JLO   = LIT_W - DATA_W;

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] jump_pc;
  logic [ADDR_W-1:0] pcl_pc;

  always_comb begin
    seq_pc  = pc_q + 1'b1;
    jump_pc = {latch_hi[HI_W-1:JLO], lit};
    pcl_pc  = {latch_hi, pcl_data};
  end

  always_comb begin
    pc_nxt    = seq_pc;
    push      = 1'b0;
    pop       = 1'b0;
    flush_nxt = 1'b0;
    gie_nxt   = 1'b0;
    if (!flush_q) begin
      unique case (ev)
        EV_STEP: ;
        EV_GOTO: begin
          pc_nxt    = jump_pc;
          flush_nxt = 1'b1;
        end
        EV_CALL: begin
          pc_nxt    = jump_pc;
          push      = 1'b1;
          flush_nxt = 1'b1;
        end
        EV_RET, EV_RETLIT: begin
          pc_nxt    = tos;
          pop       = 1'b1;
          flush_nxt = 1'b1;
        end
        EV_RETINT: begin
          pc_nxt    = tos;
          pop       = 1'b1;
          flush_nxt = 1'b1;
          gie_nxt   = 1'b1;
        end
        EV_PCLWR: begin
          pc_nxt    = pcl_pc;
          flush_nxt = 1'b1;
        end
        EV_SKIP: flush_nxt = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pc_flow_unit.sv
module pc_flow_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LIT_W  = 11,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EV_W-1:0]   ev_code,
  input  logic [LIT_W-1:0]  lit,
  input  logic [DATA_W-1:0] pcl_data,
  input  logic              latch_we,
  input  logic [DATA_W-1:0] latch_data,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] pcl_rd,
  output logic [DATA_W-1:0] latch_q,
  output logic              flush,
  output logic              gie_set
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_nxt;
  logic [ADDR_W-1:0] tos;
  logic              flush_q;
  logic              flush_nxt;
  logic              gie_q;
  logic              gie_nxt;
  logic              push;
  logic              pop;

  pcu_hold_latch #(.DATA_W(DATA_W)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .accept (!flush_q),
    .we     (latch_we),
    .wdata  (latch_data),
    .q      (latch_q)
  );

  pcu_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .push_data (pc_q),
    .tos       (tos)
  );

  pcu_next_pc #(.ADDR_W(ADDR_W), .LIT_W(LIT_W), .DATA_W(DATA_W)) u_next (
    .flush_q   (flush_q),
    .ev        (pcu_ev_e'(ev_code)),
    .pc_q      (pc_q),
    .lit       (lit),
    .pcl_data  (pcl_data),
    .latch_hi  (latch_q[HI_W-1:0]),
    .tos       (tos),
    .pc_nxt    (pc_nxt),
    .push      (push),
    .pop       (pop),
    .flush_nxt (flush_nxt),
    .gie_nxt   (gie_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      flush_q <= 1'b0;
      gie_q   <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      flush_q <= flush_nxt;
      gie_q   <= gie_nxt;
    end
  end

  assign fetch_addr = pc_q;
  assign pcl_rd     = pc_q[DATA_W-1:0];
  assign flush      = flush_q;
  assign gie_set    = gie_q;
endmodule

// File: rtl/pcu_flow_chk.sv
module pcu_flow_chk
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LIT_W  = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [EV_W-1:0]   ev_code,
  input logic [LIT_W-1:0]  lit,
  input logic [DATA_W-1:0] pcl_data,
  input logic              latch_we,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [DATA_W-1:0] latch_q,
  input logic              flush,
  input logic              gie_set
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam int JLO  = LIT_W - DATA_W;

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!flush && ev_code == EV_STEP) |=>
      (fetch_addr == $past(fetch_addr) + 1'b1) && !flush);

  assert_goto_R3: assert property (@(posedge clk) disable iff (rst)
    (!flush && ev_code == EV_GOTO) |=>
      flush && (fetch_addr == {$past(latch_q[HI_W-1:JLO]), $past(lit)}));

  assert_gie_src_R5: assert property (@(posedge clk) disable iff (rst)
    gie_set |-> ($past(ev_code) == EV_RETINT) && !$past(flush));

  assert_gie_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    gie_set |=> !gie_set);

  assert_pclwr_R6: assert property (@(posedge clk) disable iff (rst)
    (!flush && ev_code == EV_PCLWR) |=>
      flush && (fetch_addr == {$past(latch_q[HI_W-1:0]), $past(pcl_data)}));

  assert_flush_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fetch_addr == $past(fetch_addr) + 1'b1) && !flush
              && $stable(latch_q) && !gie_set);

  assert_latch_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !latch_we |=> $stable(latch_q));
endmodule

bind pc_flow_unit pcu_flow_chk #(
  .ADDR_W (ADDR_W),
  .LIT_W  (LIT_W),
  .DATA_W (DATA_W)
) u_flow_chk (
  .clk        (clk),
  .rst        (rst),
  .ev_code    (ev_code),
  .lit        (lit),
  .pcl_data   (pcl_data),
  .latch_we   (latch_we),
  .fetch_addr (fetch_addr),
  .latch_q    (latch_q),
  .flush      (flush),
  .gie_set    (gie_set)
);

// File: tb/pc_flow_unit_test.sv
module pc_flow_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ev_code = 3'd0;
  logic [10:0] lit = '0;
  logic [7:0]  pcl_data = '0;
  logic        latch_we = 1'b0;
  logic [7:0]  latch_data = '0;
  logic [12:0] fetch_addr;
  logic [7:0]  pcl_rd;
  logic [7:0]  latch_q;
  logic        flush;
  logic        gie_set;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  logic [12:0] m_pc = '0;
  logic [7:0]  m_lat = '0;
  logic        m_fl = 1'b0;
  logic        m_gie = 1'b0;
  logic [12:0] m_stk [8];
  int          m_sp = 0;

  always #(PERIOD/2) clk = ~clk;

  pc_flow_unit uut (
    .clk(clk), .rst(rst), .ev_code(ev_code), .lit(lit), .pcl_data(pcl_data),
    .latch_we(latch_we), .latch_data(latch_data), .fetch_addr(fetch_addr),
    .pcl_rd(pcl_rd), .latch_q(latch_q), .flush(flush), .gie_set(gie_set)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " fetch_addr"}, int'(fetch_addr), int'(m_pc));
    cmp({tag, " flush"}, int'(flush), int'(m_fl));
    cmp("R5 gie_set", int'(gie_set), int'(m_gie));
    cmp("R7/R11 latch_q", int'(latch_q), int'(m_lat));
    cmp("R7 pcl_rd", int'(pcl_rd), int'(m_pc[7:0]));
  endtask

  // Applies one instruction cycle, updates the reference, checks after the edge.
  task automatic cyc(input logic [2:0] ev, input logic [10:0] l, input logic [7:0] pd,
                     input logic we, input logic [7:0] ld, input string tag);
    logic [12:0] nxt;
    ev_code = ev; lit = l; pcl_data = pd; latch_we = we; latch_data = ld;
    @(posedge clk);
    nxt = m_pc + 13'd1;
    if (m_fl) begin
      m_fl = 1'b0; m_gie = 1'b0;
    end else begin
      m_fl = (ev != 3'd0);
      m_gie = (ev == 3'd5);
      case (ev)
        3'd1: nxt = {m_lat[4:3], l};
        3'd2: begin
          m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8;
          nxt = {m_lat[4:3], l};
        end
        3'd3, 3'd4, 3'd5: begin
          m_sp = (m_sp + 7) % 8; nxt = m_stk[m_sp];
        end
        3'd6: nxt = {m_lat[4:0], pd};
        default: ;
      endcase
      if (we) m_lat = ld;
    end
    m_pc = nxt;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    // R2: sequential advance
    for (int i = 0; i < 20; i++) cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R2 step");

    // R2: wrap at top of address space, R11 latch then jump
    cyc(3'd0, 11'h0, 8'h0, 1'b1, 8'hF8, "R11 latch write");
    cyc(3'd1, 11'h7FF, 8'h0, 1'b0, 8'h0, "R3 goto top");
    cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R9 flush");
    cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R2 wrap");

    // R3: sweep of every literal with rotating upper latch bits
    for (int i = 0; i < 2048; i++) begin
      cyc(3'd0, 11'h0, 8'h0, 1'b1, 8'(((i % 4) << 3) | 8'hA5 & 8'hE7), "R11 latch");
      cyc(3'd1, 11'(i), 8'h0, 1'b0, 8'h0, "R3 goto");
      cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R9 flush");
    end

    // R6: low-byte write over all latch-high and data combinations
    for (int h = 0; h < 32; h++) begin
      cyc(3'd0, 11'h0, 8'h0, 1'b1, 8'(8'hA0 | h), "R11 latch");
      for (int d = 0; d < 256; d++) begin
        cyc(3'd6, 11'h0, 8'(d), 1'b0, 8'h0, "R6 pcl write");
        cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R9 flush");
      end
    end

    // R8: taken skip
    for (int i = 0; i < 8; i++) begin
      cyc(3'd7, 11'h0, 8'h0, 1'b0, 8'h0, "R8 skip");
      cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R9 flush");
      cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R2 step");
    end

    // R9: inputs during flush are ignored, including latch writes
    cyc(3'd1, 11'h123, 8'h0, 1'b0, 8'h0, "R3 goto");
    cyc(3'd1, 11'h456, 8'h77, 1'b1, 8'h1F, "R9 ignored goto");
    cyc(3'd6, 11'h0, 8'h55, 1'b0, 8'h0, "R6 pcl write");
    cyc(3'd5, 11'h0, 8'h0, 1'b0, 8'h0, "R9 ignored retint");

    // R11: latch write and jump in the same cycle use old latch
    cyc(3'd0, 11'h0, 8'h0, 1'b1, 8'h08, "R11 latch");
    cyc(3'd1, 11'h0AA, 8'h0, 1'b1, 8'h10, "R11 old latch jump");
    cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R9 flush");

    // R4/R5/R10: nine nested calls then nine returns of mixed flavours
    for (int i = 0; i < 9; i++) begin
      cyc(3'd0, 11'h0, 8'h0, 1'b1, 8'(i << 3), "R11 latch");
      cyc(3'd2, 11'(16 * i + 3), 8'h0, 1'b0, 8'h0, "R4 call");
      cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R9 flush");
      cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R2 step");
    end
    for (int i = 0; i < 9; i++) begin
      cyc(3'(3 + (i % 3)), 11'h0, 8'h0, 1'b0, 8'h0, "R5/R10 return");
      cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R9 flush");
      cyc(3'd0, 11'h0, 8'h0, 1'b0, 8'h0, "R2 step");
    end

    // R1: reset mid-run
    ev_code = 3'd1; lit = 11'h3FF;
    rst = 1'b1;
    @(posedge clk);
    m_pc = '0; m_lat = '0; m_fl = 1'b0; m_gie = 1'b0; m_sp = 0;
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset again");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule